// File: doc/BRIEF.md
# Packet Header Field Match Cell

This block is a single classifier cell that watches a byte stream of packets and decides, for every packet, whether one header field satisfies a masked equality test. A configuration holds four settings: a byte offset from the first byte of the packet, a field length of one to four bytes, a 32-bit mask and a 32-bit compare value. While a packet streams past, the cell collects the bytes that fall inside the configured window. When the last byte arrives, it gives one verdict: match, mismatch, or out of bounds.

The settings are applied directly to the stream, so the cell never loads them per packet. Because the settings may come from an untrusted source, every verdict is guarded. A window that runs past the end of the packet is never reported as a match. A window that does not start on a 4-byte boundary raises an alignment flag next to the verdict, and the verdict is still computed. New settings are accepted only while no packet is open, so a packet is always judged against one consistent configuration.

Top module: `pfm_match_cell`

## Requirements
- R1: After reset all four result outputs are low and the settings are offset 0, length 1, mask 0 and value 0, so the first complete packet of one or more bytes gives `hit` with `misaligned` low.
- R2: The field is formed from the bytes at positions offset to offset+length-1, where position 0 is the `in_sop` byte. The first of these bytes becomes the most significant byte, and the result is zero-extended to 32 bits.
- R3: When the window lies inside the packet and (field AND mask) equals the compare value exactly, the verdict is `hit`. Value bits outside the mask therefore prevent a hit.
- R4: When the window lies inside the packet and (field AND mask) differs from the compare value, the verdict is `miss`.
- R5: The packet length is the number of accepted bytes from the `in_sop` byte through the `in_eop` byte inclusive, and cycles with `in_valid` low are not counted. When offset+length exceeds the packet length, the verdict is `oob`, and neither `hit` nor `miss` is raised.
- R6: When the offset is not a multiple of 4, `misaligned` is high in the verdict cycle together with the verdict, and the verdict itself is unchanged. At all other times `misaligned` is low.
- R7: The verdict is high for exactly the one cycle after the clock edge that accepts the `in_eop` byte. Exactly one of `hit`, `miss` and `oob` is high in that cycle, and all three are low in every other cycle.
- R8: A configuration write (`cfg_we` high at a clock edge) is taken only when no packet is open and no byte is being presented. A write made during a packet, including during its idle gaps, has no effect.
- R9: A configuration write whose length is 0 or greater than 4 is ignored, and the previous settings stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the four settings |
| cfg_offset | input | 8 | Byte offset of the field from the packet start |
| cfg_len | input | 3 | Field length in bytes, 1 to 4 |
| cfg_mask | input | 32 | Mask applied to the field |
| cfg_value | input | 32 | Value compared with the masked field |
| in_valid | input | 1 | A packet byte is presented this cycle |
| in_sop | input | 1 | The presented byte is the first of a packet |
| in_eop | input | 1 | The presented byte is the last of a packet |
| in_data | input | 8 | Packet byte |
| hit | output | 1 | Verdict: masked field equals the value |
| miss | output | 1 | Verdict: masked field differs from the value |
| oob | output | 1 | Verdict: the field window runs past the packet end |
| misaligned | output | 1 | The offset is not 4-byte aligned, shown with the verdict |

## Verification
All four result outputs are registered once, so the outputs for a packet appear in the cycle right after the edge that accepts its `in_eop` byte and are gone one cycle later. The bench drives every input on the falling edge. It reads the verdict at the falling edge that follows the end-of-packet edge, then reads again one cycle later to confirm that all outputs have returned low. A configuration write takes effect at the edge where it is sampled, so each write is completed, with its strobe dropped, before the next packet's first byte. Writes attempted during a packet are checked through the verdict that packet produces.

// File: rtl/pfm_pkg.sv
// Package for the packet field match cell.
// Holds the verdict encoding that the verdict stage uses internally.
package pfm_pkg;

    // Verdict of one packet evaluation.
    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_MATCH = 2'd1,
        VERD_MISS  = 2'd2,
        VERD_OOB   = 2'd3
    } verdict_e;

endpackage

// File: rtl/pfm_cfg_reg.sv
// Configuration holder for the match cell.
// Takes a settings write only between packets and only when the length
// is legal. Precomputes the index of the last field byte and the
// alignment flag, so the stream path needs no arithmetic on the settings.
// Assumes WORD_BYTES is a power of two.
module pfm_cfg_reg #(
    parameter int OFS_W       = 8,
    parameter int FIELD_BYTES = 4,
    parameter int WORD_BYTES  = 4,
    parameter int LEN_W       = $clog2(FIELD_BYTES + 1),
    parameter int DATA_W      = 8 * FIELD_BYTES,
    parameter int END_W       = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              pkt_open,
    input  logic              beat,
    input  logic [OFS_W-1:0]  wr_offset,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [DATA_W-1:0] wr_value,
    output logic [OFS_W-1:0]  cur_offset,
    output logic [END_W-1:0]  cur_last,
    output logic [DATA_W-1:0] cur_mask,
    output logic [DATA_W-1:0] cur_value,
    output logic              cur_misalign
);

    localparam int ALIGN_W = $clog2(WORD_BYTES);

    logic             len_ok;
    logic             accept;
    logic [END_W-1:0] new_last;
    logic             new_misalign;

    // Decide whether this write is legal and may be taken now.
    always_comb begin
        len_ok   = (wr_len != '0) && (int'(wr_len) <= FIELD_BYTES);
        accept   = wr_en && len_ok && !pkt_open && !beat;
        new_last = END_W'(wr_offset) + END_W'(wr_len) - END_W'(1);
    end

    // Alignment test; word size one means every offset is aligned.
    generate
        if (ALIGN_W == 0) begin : g_no_align
            assign new_misalign = 1'b0;
        end else begin : g_align
            assign new_misalign = |wr_offset[ALIGN_W-1:0];
        end
    endgenerate

    // Hold the settings; reset gives offset 0, length 1, mask 0, value 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_offset   <= '0;
            cur_last     <= '0;
            cur_mask     <= '0;
            cur_value    <= '0;
            cur_misalign <= 1'b0;
        end else if (accept) begin
            cur_offset   <= wr_offset;
            cur_last     <= new_last;
            cur_mask     <= wr_mask;
            cur_value    <= wr_value;
            cur_misalign <= new_misalign;
        end
    end

endmodule

// File: rtl/pfm_byte_tracker.sv
// Packet framing tracker.
// Tracks whether a packet is open and gives each accepted byte its index
// from the start byte. A byte presented with no packet open and no start
// marker is not accepted. A start marker always opens a new packet.
// The index saturates at its maximum.
module pfm_byte_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             sop,
    input  logic             eop,
    output logic             pkt_open,
    output logic             beat,
    output logic             last_beat,
    output logic [CNT_W-1:0] idx
);

    localparam logic [CNT_W-1:0] IDX_MAX = '1;

    logic [CNT_W-1:0] next_idx;

    // Classify the current cycle and give the index of the current byte.
    always_comb begin
        beat      = byte_valid && (sop || pkt_open);
        last_beat = beat && eop;
        idx       = sop ? '0 : next_idx;
    end

    // Advance the packet state on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_open <= 1'b0;
            next_idx <= '0;
        end else if (beat) begin
            pkt_open <= !eop;
            next_idx <= (idx == IDX_MAX) ? idx : idx + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pfm_field_capture.sv
// Field window capture.
// Shifts in the bytes whose index falls between the offset and the last
// field index, first byte ending up most significant. The start byte
// clears the collected field. The next-state value is also given out, so
// that the byte arriving with the end marker is part of the verdict.
module pfm_field_capture #(
    parameter int CNT_W  = 16,
    parameter int OFS_W  = 8,
    parameter int END_W  = OFS_W + 1,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic              sop,
    input  logic [CNT_W-1:0]  idx,
    input  logic [OFS_W-1:0]  cur_offset,
    input  logic [END_W-1:0]  cur_last,
    input  logic [7:0]        byte_data,
    output logic [DATA_W-1:0] field_next
);

    logic [DATA_W-1:0] field_q;
    logic [DATA_W-1:0] base;
    logic              in_win;

    // Work out whether this byte is in the window and form the next field.
    always_comb begin
        in_win = (idx >= CNT_W'(cur_offset)) && (idx <= CNT_W'(cur_last));
        base   = sop ? '0 : field_q;
        if (beat && in_win) begin
            field_next = {base[DATA_W-9:0], byte_data};
        end else if (beat) begin
            field_next = base;
        end else begin
            field_next = field_q;
        end
    end

    // Store the collected field between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
        end else begin
            field_q <= field_next;
        end
    end

endmodule

// File: rtl/pfm_verdict.sv
// Verdict stage.
// On the end byte, compares the packet length with the last field index,
// then the masked field with the value, and registers a one-cycle verdict.
// The bounds test takes priority, so an out-of-bounds field never matches.
module pfm_verdict
    import pfm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int END_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_beat,
    input  logic [CNT_W-1:0]  idx,
    input  logic [END_W-1:0]  cur_last,
    input  logic [DATA_W-1:0] cur_mask,
    input  logic [DATA_W-1:0] cur_value,
    input  logic              cur_misalign,
    input  logic [DATA_W-1:0] field_next,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_oob,
    output logic              res_misalign
);

    verdict_e verd;

    // Bounds first, then the masked compare; no verdict off the end byte.
    always_comb begin
        if (!last_beat) begin
            verd = VERD_NONE;
        end else if (CNT_W'(cur_last) > idx) begin
            verd = VERD_OOB;
        end else if ((field_next & cur_mask) == cur_value) begin
            verd = VERD_MATCH;
        end else begin
            verd = VERD_MISS;
        end
    end

    // Register the verdict for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit      <= 1'b0;
            res_miss     <= 1'b0;
            res_oob      <= 1'b0;
            res_misalign <= 1'b0;
        end else begin
            res_hit      <= (verd == VERD_MATCH);
            res_miss     <= (verd == VERD_MISS);
            res_oob      <= (verd == VERD_OOB);
            res_misalign <= last_beat && cur_misalign;
        end
    end

endmodule

// File: rtl/pfm_match_cell.sv
// Packet header field match cell, top level.
// Joins the settings holder, the framing tracker, the window capture and
// the verdict stage. Assumes one byte per cycle at most and that CNT_W is
// at least OFS_W + 1.
module pfm_match_cell #(
    parameter int OFS_W       = 8,
    parameter int FIELD_BYTES = 4,
    parameter int WORD_BYTES  = 4,
    parameter int CNT_W       = 16,
    parameter int LEN_W       = $clog2(FIELD_BYTES + 1),
    parameter int DATA_W      = 8 * FIELD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFS_W-1:0]  cfg_offset,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [DATA_W-1:0] cfg_value,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_data,
    output logic              hit,
    output logic              miss,
    output logic              oob,
    output logic              misaligned
);

    localparam int END_W = OFS_W + 1;

    logic              pkt_open;
    logic              beat;
    logic              last_beat;
    logic [CNT_W-1:0]  idx;
    logic [OFS_W-1:0]  cur_offset;
    logic [END_W-1:0]  cur_last;
    logic [DATA_W-1:0] cur_mask;
    logic [DATA_W-1:0] cur_value;
    logic              cur_misalign;
    logic [DATA_W-1:0] field_next;

    pfm_cfg_reg #(
        .OFS_W(OFS_W), .FIELD_BYTES(FIELD_BYTES), .WORD_BYTES(WORD_BYTES),
        .LEN_W(LEN_W), .DATA_W(DATA_W), .END_W(END_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .pkt_open(pkt_open),
        .beat(beat), .wr_offset(cfg_offset), .wr_len(cfg_len),
        .wr_mask(cfg_mask), .wr_value(cfg_value), .cur_offset(cur_offset),
        .cur_last(cur_last), .cur_mask(cur_mask), .cur_value(cur_value),
        .cur_misalign(cur_misalign)
    );

    pfm_byte_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .byte_valid(in_valid), .sop(in_sop),
        .eop(in_eop), .pkt_open(pkt_open), .beat(beat),
        .last_beat(last_beat), .idx(idx)
    );

    pfm_field_capture #(
        .CNT_W(CNT_W), .OFS_W(OFS_W), .END_W(END_W), .DATA_W(DATA_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .beat(beat), .sop(in_sop), .idx(idx),
        .cur_offset(cur_offset), .cur_last(cur_last), .byte_data(in_data),
        .field_next(field_next)
    );

    pfm_verdict #(.CNT_W(CNT_W), .END_W(END_W), .DATA_W(DATA_W)) u_ver (
        .clk(clk), .rst_n(rst_n), .last_beat(last_beat), .idx(idx),
        .cur_last(cur_last), .cur_mask(cur_mask), .cur_value(cur_value),
        .cur_misalign(cur_misalign), .field_next(field_next),
        .res_hit(hit), .res_miss(miss), .res_oob(oob),
        .res_misalign(misaligned)
    );

endmodule

// File: rtl/pfm_match_cell_chk.sv
// Property checker for the match cell, bound to the top level.
// Watches the stream ports, the verdict outputs and the held settings.
module pfm_match_cell_chk #(
    parameter int OFS_W = 8,
    parameter int LEN_W = 3,
    parameter int FIELD_BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [LEN_W-1:0] cfg_len,
    input logic             in_valid,
    input logic             in_sop,
    input logic             in_eop,
    input logic             hit,
    input logic             miss,
    input logic             oob,
    input logic             misaligned,
    input logic             pkt_open,
    input logic [OFS_W-1:0] cur_offset,
    input logic [OFS_W:0]   cur_last
);

    logic end_byte;
    logic any_res;
    logic bad_len;

    assign end_byte = in_valid && in_eop && (in_sop || pkt_open);
    assign any_res  = hit || miss || oob;
    assign bad_len  = (cfg_len == '0) || (int'(cfg_len) > FIELD_BYTES);

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, miss, oob})); // R7
    AST_END_GIVES_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        end_byte |=> any_res); // R7
    AST_VERDICT_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        any_res |-> $past(end_byte)); // R7
    AST_ALIGN_WITH_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> any_res); // R6
    AST_CFG_HELD_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_open |=> ($stable(cur_offset) && $stable(cur_last))); // R8
    AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && bad_len) |=> ($stable(cur_offset) && $stable(cur_last))); // R9

endmodule

bind pfm_match_cell pfm_match_cell_chk #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .FIELD_BYTES(FIELD_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .hit(hit),
    .miss(miss), .oob(oob), .misaligned(misaligned), .pkt_open(pkt_open),
    .cur_offset(cur_offset), .cur_last(cur_last)
);

// File: tb/tb_pfm_match_cell.sv
`timescale 1ns/1ps
module tb_pfm_match_cell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_offset = '0;
    logic [2:0]  cfg_len = '0;
    logic [31:0] cfg_mask = '0;
    logic [31:0] cfg_value = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        hit, miss, oob, misaligned;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench copy of the settings in force.
    int          m_off  = 0;
    int          m_len  = 1;
    logic [31:0] m_mask = '0;
    logic [31:0] m_val  = '0;

    always #2.5 clk = ~clk;

    pfm_match_cell dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_offset(cfg_offset),
        .cfg_len(cfg_len), .cfg_mask(cfg_mask), .cfg_value(cfg_value),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .hit(hit), .miss(miss), .oob(oob),
        .misaligned(misaligned)
    );

    function automatic logic [7:0] pb(input int i, input int seed);
        return 8'((i * 53 + seed * 17 + 5) & 255);
    endfunction

    function automatic logic [31:0] field_of(input int off, input int len, input int seed);
        logic [31:0] f = '0;
        for (int k = 0; k < len; k++) f = {f[23:0], pb(off + k, seed)};
        return f;
    endfunction

    // Expected {hit, miss, oob, misaligned} from the settings in force.
    function automatic logic [3:0] expect_vec(input int plen, input int seed);
        logic [31:0] f;
        logic        mis;
        mis = (m_off % 4) != 0;
        if (m_off + m_len > plen) return {3'b001, mis};
        f = field_of(m_off, m_len, seed);
        if ((f & m_mask) == m_val) return {3'b100, mis};
        return {3'b010, mis};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int off, input int len, input logic [31:0] mask,
                             input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_offset = 8'(off); cfg_len = 3'(len);
        cfg_mask = mask; cfg_value = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (len >= 1 && len <= 4) begin
            m_off = off; m_len = len; m_mask = mask; m_val = val;
        end
    endtask

    // Send one packet; gap adds an idle cycle after byte 0, poke drives
    // junk settings writes for the whole packet. Checks verdict and clear.
    task automatic send_pkt(input int plen, input int seed, input bit gap,
                            input bit poke, input string req);
        logic [3:0] exp;
        exp = expect_vec(plen, seed);
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            if (poke) begin
                cfg_we = 1'b1; cfg_offset = '0; cfg_len = 3'd1;
                cfg_mask = '0; cfg_value = '0;
            end
            in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == plen - 1);
            in_data = pb(i, seed);
            if (gap && i == 1) begin
                in_valid = 1'b0;
                @(negedge clk);
                in_valid = 1'b1;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        chk(req, {28'd0, hit, miss, oob, misaligned}, {28'd0, exp});
        @(negedge clk);
        chk("R7 pulse clears", {28'd0, hit, miss, oob, misaligned}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] f;
        logic [31:0] mk;
        int          sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs low after reset, default settings hit.
        chk("R1 reset outputs", {28'd0, hit, miss, oob, misaligned}, 32'd0);
        send_pkt(3, 1, 1'b0, 1'b0, "R1 default settings");

        // R2 R3 R4 R5 R6: sweep offset, length and packet length.
        for (int off = 0; off < 7; off++) begin
            for (int len = 1; len <= 4; len++) begin
                for (int plen = 1; plen <= 10; plen++) begin
                    f   = field_of(off, len, off + plen);
                    sel = (off + len + plen) % 4;
                    case (sel)
                        0: begin mk = 32'hFFFF_FFFF; cfg_write(off, len, mk, f & mk); end
                        1: begin mk = 32'h0F0F_0F0F; cfg_write(off, len, mk, f & mk); end
                        2: begin mk = 32'hFFFF_00FF; cfg_write(off, len, mk, (f & mk) ^ 32'h1); end
                        default: begin mk = 32'h00FF_FFFF; cfg_write(off, len, mk, (f & mk) | 32'h8000_0000); end
                    endcase
                    send_pkt(plen, off + plen, (plen % 4) == 3, 1'b0,
                             "R2 R3 R4 R5 R6 sweep");
                end
            end
        end

        // R8: writes during a packet and its gap have no effect.
        f = field_of(2, 2, 9);
        cfg_write(2, 2, 32'h0000_FFFF, f ^ 32'h1);
        send_pkt(6, 9, 1'b1, 1'b1, "R8 write in packet ignored");
        send_pkt(6, 9, 1'b0, 1'b0, "R8 settings kept");

        // R9: illegal lengths are ignored.
        f = field_of(1, 2, 4);
        cfg_write(1, 2, 32'hFFFF_FFFF, f);
        cfg_write(0, 0, 32'h0, 32'h1);
        cfg_write(0, 5, 32'h0, 32'h1);
        cfg_write(3, 7, 32'h0, 32'h1);
        send_pkt(5, 4, 1'b0, 1'b0, "R9 bad length ignored");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule